// File: doc/BRIEF.md
# Interrupt Status and Mask Unit

This block gathers one-cycle event pulses from the receive, transmit, PHY and bus-error logic of a network controller. Each pulse sets a sticky bit in a 26-bit status register. A read of the status offset returns the collected bits and clears them. A mask register picks which status bits can raise the interrupt, and a global enable bit gates the single level-sensitive interrupt line.

Bit 15 of the status word is not an event. It reads as the OR of bits 25 to 16, so one mask bit can stand for the whole group of error and reset-done events. The host can also raise the software event, bit 12, by writing a command bit.

Top module: `irq_status_unit`

## Requirements
- R1: After a synchronous active-low reset, the status, mask and enable registers read as zero and `irq_o` is low.
- R2: A pulse on an assigned event line sets its status bit one clock later. The bit stays set until a status read. The assigned lines are 0-11, 13, 14, 16 and 20-25.
- R3: A read of the status register at offset 0x10 returns the accumulated bits in the same cycle. The bits are zero from the following clock edge on.
- R4: An event that arrives in the same cycle as a clearing status read is missing from that read's data. Its bit is set afterwards.
- R5: Status bit 15 reads as the OR of bits 25 to 16. Bits 17-19 always read zero. Event lines 12, 15 and 17-19 have no effect on the status.
- R6: The mask register at offset 0x14 holds write-data bits 25:0. The enable register at offset 0x18 holds write-data bit 0. Both read back what was written, and unused bits read as zero.
- R7: `irq_o` is high exactly when the enable bit is 1 and the status word as read, bit 15 included, ANDed with the mask is non-zero.
- R8: Writing 1 to write-data bit 0 at the command offset 0x1C sets status bit 12 one clock later.
- R9: Reads of the mask or enable offsets leave the status unchanged, and so do writes to the status offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_i | input | 26 | One-cycle event pulses, one line per status bit |
| host_rd_i | input | 1 | Host read strobe; data on `host_rdata_o` in the same cycle |
| host_wr_i | input | 1 | Host write strobe |
| host_addr_i | input | 8 | Byte offset of the register |
| host_wdata_i | input | 32 | Write data |
| host_rdata_o | output | 32 | Read data |
| irq_o | output | 1 | Level-sensitive interrupt request |

## Verification
The main sweep sends a pulse on each of the 26 event lines in turn. It then reads the status twice. This shows which bits are assigned, that the summary bit follows only the high group, and that a read clears the status. A second sweep masks one bit at a time with the enable on and then off. This shows whether the interrupt follows the masked summary and the gate. Directed patterns cover an event that lands on a clearing read, the software command, a mask pattern read back, and accesses that must not clear the status.

// File: rtl/irq_pkg.sv
// Package: register offsets and the status bit map of the interrupt unit.
// Assumes byte offsets on an 8-bit address and a 26-bit status word.
package irq_pkg;
    localparam int STS_W = 26;
    localparam int SUM_BIT = 15;
    localparam int SW_BIT = 12;
    localparam int HI_LO = 16;

    localparam logic [7:0] OFS_STS = 8'h10;
    localparam logic [7:0] OFS_MSK = 8'h14;
    localparam logic [7:0] OFS_ENA = 8'h18;
    localparam logic [7:0] OFS_CMD = 8'h1C;

    // bits that can be stored (12 only from the command path)
    localparam logic [STS_W-1:0] STORE_MAP = 26'h3F17FFF;
    // bits that an event line can set
    localparam logic [STS_W-1:0] LINE_MAP = 26'h3F16FFF;

    typedef enum logic [1:0] {SEL_STS, SEL_MSK, SEL_ENA, SEL_NONE} reg_sel_e;
endpackage

// File: rtl/irq_status_reg.sv
// Module: sticky status register with clear-on-read.
// Assumes evt_i pulses last one cycle. An event that coincides with a
// clear wins, so it is never lost.
module irq_status_reg
    import irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [STS_W-1:0] evt_i,
    input  logic             sw_evt_i,
    input  logic             clr_i,
    output logic [STS_W-1:0] sts_o
);
    logic [STS_W-1:0] set_vec;
    logic [STS_W-1:0] sts_q;

    // combine filtered line events with the software event
    always_comb begin
        set_vec = evt_i & LINE_MAP;
        set_vec[SW_BIT] = sw_evt_i;
    end

    // accumulate events, drop old bits on clear
    always_ff @(posedge clk) begin
        if (!rst_n) sts_q <= '0;
        else if (clr_i) sts_q <= set_vec;
        else sts_q <= sts_q | set_vec;
    end

    assign sts_o = sts_q;

    // R4
    evt_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((sts_q & $past(set_vec)) == $past(set_vec)));
    // R3
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> ((sts_q & ~$past(set_vec)) == '0));
    // R2
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && set_vec == '0) |=> $stable(sts_q));
    // R5
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_q & ~STORE_MAP) == '0);
endmodule

// File: rtl/irq_host_port.sv
// Module: register decode, mask and enable storage, read mux.
// Assumes one host access per cycle. Read data is combinational from
// registers, and a status read raises the clear strobe in that cycle.
module irq_host_port
    import irq_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [STS_W-1:0]  sts_view_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              clr_o,
    output logic              sw_evt_o,
    output logic [STS_W-1:0]  mask_o,
    output logic              ena_o
);
    reg_sel_e sel;
    logic [STS_W-1:0] mask_q;
    logic ena_q;

    // decode the offset into a register select
    always_comb begin
        case (addr_i)
            ADDR_W'(OFS_STS): sel = SEL_STS;
            ADDR_W'(OFS_MSK): sel = SEL_MSK;
            ADDR_W'(OFS_ENA): sel = SEL_ENA;
            default:          sel = SEL_NONE;
        endcase
    end

    // mask and enable registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            ena_q <= 1'b0;
        end else if (wr_i) begin
            if (sel == SEL_MSK) mask_q <= wdata_i[STS_W-1:0];
            if (sel == SEL_ENA) ena_q <= wdata_i[0];
        end
    end

    // read mux
    always_comb begin
        rdata_o = '0;
        case (sel)
            SEL_STS: rdata_o[STS_W-1:0] = sts_view_i;
            SEL_MSK: rdata_o[STS_W-1:0] = mask_q;
            SEL_ENA: rdata_o[0] = ena_q;
            default: rdata_o = '0;
        endcase
    end

    assign clr_o = rd_i && (sel == SEL_STS);
    assign sw_evt_o = wr_i && (addr_i == ADDR_W'(OFS_CMD)) && wdata_i[0];
    assign mask_o = mask_q;
    assign ena_o = ena_q;

    // R6
    ena_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_i && sel == SEL_ENA) |=> $stable(ena_q));
    // R6
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_i && sel == SEL_MSK) |=> $stable(mask_q));
endmodule

// File: rtl/irq_out_gen.sv
// Module: builds the host view of status (summary bit) and the
// interrupt level. Assumes sts_i holds no bit 15 of its own.
module irq_out_gen
    import irq_pkg::*;
(
    input  logic [STS_W-1:0] sts_i,
    input  logic [STS_W-1:0] mask_i,
    input  logic             ena_i,
    output logic [STS_W-1:0] view_o,
    output logic             irq_o
);
    // insert the summary of the high group into bit 15
    always_comb begin
        view_o = sts_i;
        view_o[SUM_BIT] = |sts_i[STS_W-1:HI_LO];
    end

    // gate the masked view with the global enable
    always_comb begin
        irq_o = ena_i && ((view_o & mask_i) != '0);
    end
endmodule

// File: rtl/irq_status_unit.sv
// Top: interrupt status, mask and enable unit.
// Assumes a single clock, synchronous active-low reset, and a host that
// samples read data in the cycle it raises the read strobe.
module irq_status_unit
    import irq_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STS_W-1:0]  evt_i,
    input  logic              host_rd_i,
    input  logic              host_wr_i,
    input  logic [ADDR_W-1:0] host_addr_i,
    input  logic [DATA_W-1:0] host_wdata_i,
    output logic [DATA_W-1:0] host_rdata_o,
    output logic              irq_o
);
    logic [STS_W-1:0] sts, view, mask;
    logic clr, sw_evt, ena;

    irq_status_reg u_sts (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .sw_evt_i(sw_evt),
        .clr_i(clr), .sts_o(sts)
    );

    irq_host_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
        .clk(clk), .rst_n(rst_n), .rd_i(host_rd_i), .wr_i(host_wr_i),
        .addr_i(host_addr_i), .wdata_i(host_wdata_i), .sts_view_i(view),
        .rdata_o(host_rdata_o), .clr_o(clr), .sw_evt_o(sw_evt),
        .mask_o(mask), .ena_o(ena)
    );

    irq_out_gen u_out (
        .sts_i(sts), .mask_i(mask), .ena_i(ena), .view_o(view), .irq_o(irq_o)
    );

    // R7
    gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ena |-> !irq_o);
    // R7
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sts == '0) |-> !irq_o);
    // R8
    sw_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_evt |=> sts[SW_BIT]);
endmodule

// File: tb/sim_irq_status_unit.sv
module sim_irq_status_unit;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [25:0] evt = '0;
    logic rd = 1'b0, wr = 1'b0;
    logic [7:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic irq;
    int checks = 0, errors = 0;
    logic done = 1'b0;

    always #4 clk = ~clk;

    irq_status_unit u0 (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .host_rd_i(rd),
        .host_wr_i(wr), .host_addr_i(addr), .host_wdata_i(wdata),
        .host_rdata_o(rdata), .irq_o(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic bit line_ok(input int i);
        return (i <= 14 && i != 12) || i == 16 || i >= 20;
    endfunction

    function automatic logic [31:0] exp_of(input int i);
        logic [31:0] v = '0;
        if (line_ok(i)) begin
            v[i] = 1'b1;
            if (i >= 16) v[15] = 1'b1;
        end
        return v;
    endfunction

    task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        rd = 1'b1; addr = a;
        #1 d = rdata;
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic pulse(input logic [25:0] e);
        @(negedge clk);
        evt = e;
        @(negedge clk);
        evt = '0;
    endtask

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd_reg(8'h10, d); chk("R1 status", d, 0);
        rd_reg(8'h14, d); chk("R1 mask", d, 0);
        rd_reg(8'h18, d); chk("R1 enable", d, 0);
        chk("R1 irq", {31'd0, irq}, 0);

        // R2 R3 R5 sweep of every event line
        for (int i = 0; i < 26; i++) begin
            pulse(26'd1 << i);
            rd_reg(8'h10, d); chk($sformatf("R2/R5 line %0d", i), d, exp_of(i));
            rd_reg(8'h10, d); chk($sformatf("R3 cleared %0d", i), d, 0);
        end

        // R7 sweep: one mask bit at a time
        wr_reg(8'h18, 32'h1);
        for (int i = 0; i < 26; i++) begin
            wr_reg(8'h14, 32'd1 << i);
            pulse(26'd1 << i);
            #1 chk($sformatf("R7 irq bit %0d", i), {31'd0, irq}, {31'd0, line_ok(i)});
            wr_reg(8'h18, 32'h0);
            #1 chk($sformatf("R7 gated %0d", i), {31'd0, irq}, 0);
            wr_reg(8'h18, 32'h1);
            rd_reg(8'h10, d);
            #1 chk($sformatf("R7 after clear %0d", i), {31'd0, irq}, 0);
        end
        // R7 summary-only mask picks a high event
        wr_reg(8'h14, 32'h8000);
        pulse(26'd1 << 22);
        #1 chk("R7 summary irq", {31'd0, irq}, 1);
        rd_reg(8'h10, d); chk("R5 summary read", d, 32'h0040_8000);

        // R4 event on a clearing read
        pulse(26'h1);
        @(negedge clk);
        rd = 1'b1; addr = 8'h10; evt = 26'h40;
        #1 d = rdata;
        @(negedge clk);
        rd = 1'b0; evt = '0;
        chk("R4 read data", d, 32'h1);
        rd_reg(8'h10, d); chk("R4 kept", d, 32'h40);

        // R8 software command; line 12 ignored
        wr_reg(8'h1C, 32'h1);
        rd_reg(8'h10, d); chk("R8 sw event", d, 32'h1000);
        wr_reg(8'h1C, 32'h0);
        rd_reg(8'h10, d); chk("R8 no event on 0", d, 0);

        // R6 readback
        wr_reg(8'h14, 32'hFFFF_FFFF);
        rd_reg(8'h14, d); chk("R6 mask", d, 32'h03FF_FFFF);
        wr_reg(8'h18, 32'hFFFF_FFFE);
        rd_reg(8'h18, d); chk("R6 enable", d, 0);
        wr_reg(8'h18, 32'h3);
        rd_reg(8'h18, d); chk("R6 enable set", d, 1);

        // R9 non-clearing accesses
        pulse(26'h3);
        rd_reg(8'h14, d);
        rd_reg(8'h18, d);
        wr_reg(8'h10, 32'h0);
        rd_reg(8'h10, d); chk("R9 status kept", d, 32'h3);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                errors++; checks++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule